// File: doc/BRIEF.md
# Real-Time Clock Command/Status Controller

This block keeps a calendar clock in BCD and lets a processor load it through a small register window. Software stages a base date, a base time, a configuration word and a signed offset in seconds. None of these reach the clock until software writes a command code to the control register. While the command is in progress, the control register shows a busy flag. When the flag drops, an error flag reports whether the command worked. A successful commit loads the staged values into the live clock and starts it. A capture copies the live configuration and offset back into the staged registers so that software can read them.

After it has been started, the clock advances once per pulse on the 1 Hz input. The count carries in BCD from seconds up to years and wraps from 2099 to 2000. February has 29 days in every fourth year of that century. The weekday advances whenever the day changes. Bit 0 of the live configuration word selects how the current-time output shows the hour: 24-hour form, or 12-hour form with a PM flag.

Top module: `rtc_cmd_ctrl`

## Requirements
- R1: After reset, the control register reads 0 and `running` is 0. `now_bcd` shows year 00, month 01, day 01, weekday 0, 00:00:00.
- R2: The controller must be idle for a command to start. Any nonzero value written to control (address 0, low 16 bits) while idle sets busy (read bit 15) and clears error (read bit 14). Busy stays high for exactly BUSY_CYCLES (8) clock cycles and then drops.
- R3: Control writes made while busy is set are ignored. They neither extend busy nor change the command in progress or its result.
- R4: Command 1 with a valid staged base does four things. It loads the base into the clock, copies the staged configuration and offset to the live copies, sets `running`, and finishes with bit 14 clear.
- R5: Command 1 finishes with bit 14 set in two cases: some staged byte holds a nibble above 9, or a field is out of range. The valid ranges are month 01–12, day 01–31, weekday 0–6, hour 00–23, and minute and second 00–59. In that case the clock, the live copies and `running` keep their previous values.
- R6: Command 2 copies the live configuration and offset into the staged registers at addresses 3 and 4 and finishes with bit 14 clear. Any other nonzero code finishes with bit 14 set and changes nothing.
- R7: Writing 0 to control while idle clears bit 14 and does not set busy.
- R8: While `running` is 1, each `tick_1hz` pulse adds one second, with BCD carries through minute, hour, day, month and year, and year 99 wraps to 00. While `running` is 0, ticks have no effect.
- R9: The last day of a month is 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the year is divisible by 4 and 28 otherwise. For all other months it is 31.
- R10: The weekday advances by one with each day rollover and wraps from 6 to 0.
- R11: When live configuration bit 0 is 1, the hour byte of `now_bcd` is shown in 12-hour form. Hour 00 shows as 0x12, hours 01–11 show unchanged, hour 12 shows as 0x92, and hours 13–23 show as (hour−12) with bit 7 set.
- R12: The register map is 0 control, 1 date, 2 time, 3 configuration, 4 offset. The date word holds year in [7:0], month in [15:8], day in [23:16] and weekday in [31:24]. The time word holds hour in [7:0], minute in [15:8] and second in [23:16]. Staged registers read back as written. `now_bcd` packs, from byte 0 up: year, month, day, weekday, hour, minute, second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| now_bcd | output | 56 | Current date and time in BCD |
| running | output | 1 | Clock started by a successful commit |

## Verification
If the command sequencer holds the wrong state, the control word is wrong. Busy is then too long or too short, or bit 14 has the wrong value. That shows one cycle after the eighth busy cycle. A wrong validity decision either lets a bad base reach `now_bcd` or blocks a good one, and the result is visible two cycles after busy drops. A faulty carry or month-length term stays hidden until a tick crosses that boundary. That is why the stimulus loads values one second before the end of a month, a leap-year February and the century. The wrong digit then appears on `now_bcd` one cycle after the tick.

// File: rtl/rtc_cfg_pkg.sv
package rtc_cfg_pkg;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_DATE = 3'd1;
  localparam logic [REG_AW-1:0] A_TIME = 3'd2;
  localparam logic [REG_AW-1:0] A_CFG  = 3'd3;
  localparam logic [REG_AW-1:0] A_OFFS = 3'd4;

  localparam logic [15:0] CMD_IDLE    = 16'd0;
  localparam logic [15:0] CMD_COMMIT  = 16'd1;
  localparam logic [15:0] CMD_CAPTURE = 16'd2;

  typedef enum logic {S_IDLE, S_BUSY} cmd_st_e;

  // first member is the most significant byte: year ends up in [7:0]
  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                     wday: 8'h00, day: 8'h01, mon: 8'h01,
                                     year: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_digits_ok(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  // divisible by four, worked out on the two BCD digits
  function automatic logic leap_year(input logic [7:0] y);
    logic u048, u26;
    u048 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    u26  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? u26 : u048;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_12h(input logic [7:0] h);
    logic [6:0] b;
    b = 7'(h[7:4]) * 7'd10 + 7'(h[3:0]);
    if (b == 7'd0)       return 8'h12;
    else if (b < 7'd12)  return h;
    else if (b == 7'd12) return 8'h92;
    else begin
      b = b - 7'd12;
      return {1'b1, 3'(b / 7'd10), 4'(b % 7'd10)};
    end
  endfunction

endpackage

// File: rtl/rtc_bcd_check.sv
module rtc_bcd_check
  import rtc_cfg_pkg::*;
(
  input  rtc_time_t t_i,
  output logic      ok_o
);
  localparam int NB = $bits(rtc_time_t) / 8;

  logic [8*NB-1:0] flat;
  logic [NB-1:0]   dig_ok;
  logic            range_ok;

  assign flat = t_i;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_dig
      assign dig_ok[g] = bcd_digits_ok(flat[8*g +: 8]);
    end
  endgenerate

  // BCD compares match numeric order once every nibble is a digit
  always_comb begin
    range_ok = (t_i.mon  >= 8'h01) && (t_i.mon <= 8'h12) &&
               (t_i.day  >= 8'h01) && (t_i.day <= 8'h31) &&
               (t_i.wday <= 8'h06) && (t_i.hour <= 8'h23) &&
               (t_i.min  <= 8'h59) && (t_i.sec <= 8'h59);
  end

  assign ok_o = (&dig_ok) && range_ok;

endmodule

// File: rtl/rtc_cmd_fsm.sv
module rtc_cmd_fsm
  import rtc_cfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr_i,
  input  logic [15:0] cmd_i,
  input  logic        base_ok_i,
  output logic        busy_o,
  output logic        err_o,
  output logic        commit_o,
  output logic        capture_o
);
  localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

  cmd_st_e     st;
  logic [CW-1:0] cnt;
  logic [15:0] cmd_q;
  logic        err_q;
  logic        done;
  logic        cmd_ok;

  assign done   = (st == S_BUSY) && (cnt == '0);
  assign cmd_ok = ((cmd_q == CMD_COMMIT) && base_ok_i) || (cmd_q == CMD_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      cmd_q <= CMD_IDLE;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cmd_wr_i) begin
            if (cmd_i == CMD_IDLE) begin
              err_q <= 1'b0;
            end else begin
              st    <= S_BUSY;
              cnt   <= CW'(BUSY_CYCLES - 1);
              cmd_q <= cmd_i;
              err_q <= 1'b0;
            end
          end
        end
        default: begin
          if (cnt == '0) begin
            st    <= S_IDLE;
            err_q <= !cmd_ok;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o    = (st == S_BUSY);
  assign err_o     = err_q;
  assign commit_o  = done && (cmd_q == CMD_COMMIT) && base_ok_i;
  assign capture_o = done && (cmd_q == CMD_CAPTURE);

  a_r2_done_clears: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt == '0) |=> !busy_o);

  a_r3_ignore_busy_wr: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt != '0 && cmd_wr_i) |=> (busy_o && $stable(cmd_q)));

  a_r5_bad_base_err: assert property (@(posedge clk) disable iff (rst)
    (done && cmd_q == CMD_COMMIT && !base_ok_i) |=> err_o);

  a_r6_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit_o, capture_o}));

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  input  logic      run_i,
  input  logic      tick_i,
  output rtc_time_t now_o
);
  rtc_time_t now_q;
  rtc_time_t nxt;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    nxt    = now_q;
    c_min  = (now_q.sec == 8'h59);
    c_hour = c_min  && (now_q.min  == 8'h59);
    c_day  = c_hour && (now_q.hour == 8'h23);
    c_mon  = c_day  && (now_q.day  >= month_last(now_q.mon, now_q.year));
    c_year = c_mon  && (now_q.mon  >= 8'h12);

    nxt.sec = c_min ? 8'h00 : bcd_inc(now_q.sec);
    if (c_min)  nxt.min  = c_hour ? 8'h00 : bcd_inc(now_q.min);
    if (c_hour) nxt.hour = c_day  ? 8'h00 : bcd_inc(now_q.hour);
    if (c_day) begin
      nxt.wday = (now_q.wday >= 8'h06) ? 8'h00 : now_q.wday + 8'h01;
      nxt.day  = c_mon ? 8'h01 : bcd_inc(now_q.day);
    end
    if (c_mon)  nxt.mon  = c_year ? 8'h01 : bcd_inc(now_q.mon);
    if (c_year) nxt.year = (now_q.year == 8'h99) ? 8'h00 : bcd_inc(now_q.year);
  end

  always_ff @(posedge clk) begin
    if (rst)                 now_q <= TIME_RST;
    else if (load_i)         now_q <= load_val_i;
    else if (run_i && tick_i) now_q <= nxt;
  end

  assign now_o = now_q;

  a_r8_sec_digits: assert property (@(posedge clk) disable iff (rst)
    (now_q.sec <= 8'h59) && (now_q.sec[3:0] <= 4'd9));

  a_r8_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> $stable(now_q));

  a_r10_wday_range: assert property (@(posedge clk) disable iff (rst)
    now_q.wday <= 8'h06);

endmodule

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl
  import rtc_cfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  parameter int CFG_W       = 32,
  parameter int OFFS_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [55:0]       now_bcd,
  output logic              running
);
  localparam int MODE12_BIT = 0;

  logic [31:0]       stage_date;
  logic [31:0]       stage_time;
  logic [CFG_W-1:0]  stage_cfg;
  logic [OFFS_W-1:0] stage_offs;
  logic [CFG_W-1:0]  live_cfg;
  logic [OFFS_W-1:0] live_offs;
  logic              run_q;
  logic [31:0]       rdata_q;
  rtc_time_t         disp_q;

  rtc_time_t base;
  rtc_time_t live_t;
  rtc_time_t disp_d;
  logic      base_ok;
  logic      busy, err, commit_p, capture_p;
  logic      cmd_wr;

  always_comb begin
    base.year = stage_date[7:0];
    base.mon  = stage_date[15:8];
    base.day  = stage_date[23:16];
    base.wday = stage_date[31:24];
    base.hour = stage_time[7:0];
    base.min  = stage_time[15:8];
    base.sec  = stage_time[23:16];
  end

  assign cmd_wr = bus_we && (bus_addr == A_CTRL);

  rtc_bcd_check u_check (
    .t_i  (base),
    .ok_o (base_ok)
  );

  rtc_cmd_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr_i  (cmd_wr),
    .cmd_i     (bus_wdata[15:0]),
    .base_ok_i (base_ok),
    .busy_o    (busy),
    .err_o     (err),
    .commit_o  (commit_p),
    .capture_o (capture_p)
  );

  rtc_time_counter u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (commit_p),
    .load_val_i (base),
    .run_i      (run_q),
    .tick_i     (tick_1hz),
    .now_o      (live_t)
  );

  // staged registers: a capture result takes priority over a bus write
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_date <= '0;
      stage_time <= '0;
      stage_cfg  <= '0;
      stage_offs <= '0;
    end else begin
      if (bus_we && bus_addr == A_DATE) stage_date <= bus_wdata;
      if (bus_we && bus_addr == A_TIME) stage_time <= bus_wdata;
      if (capture_p) begin
        stage_cfg  <= live_cfg;
        stage_offs <= live_offs;
      end else begin
        if (bus_we && bus_addr == A_CFG)  stage_cfg  <= CFG_W'(bus_wdata);
        if (bus_we && bus_addr == A_OFFS) stage_offs <= OFFS_W'(bus_wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_cfg  <= '0;
      live_offs <= '0;
      run_q     <= 1'b0;
    end else if (commit_p) begin
      live_cfg  <= stage_cfg;
      live_offs <= stage_offs;
      run_q     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:  rdata_q <= {16'h0, busy, err, 14'h0};
        A_DATE:  rdata_q <= stage_date;
        A_TIME:  rdata_q <= stage_time;
        A_CFG:   rdata_q <= 32'(stage_cfg);
        A_OFFS:  rdata_q <= 32'(stage_offs);
        default: rdata_q <= '0;
      endcase
    end
  end

  always_comb begin
    disp_d = live_t;
    if (live_cfg[MODE12_BIT]) disp_d.hour = hour_12h(live_t.hour);
  end

  always_ff @(posedge clk) begin
    if (rst) disp_q <= TIME_RST;
    else     disp_q <= disp_d;
  end

  assign bus_rdata = rdata_q;
  assign now_bcd   = disp_q;
  assign running   = run_q;

  a_r4_commit_starts: assert property (@(posedge clk) disable iff (rst)
    commit_p |=> run_q);

  a_r4_run_sticky: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);

  a_r6_capture_copies: assert property (@(posedge clk) disable iff (rst)
    capture_p |=> (stage_cfg == $past(live_cfg) && stage_offs == $past(live_offs)));

endmodule

// File: tb/test_rtc_cmd_ctrl.sv
module test_rtc_cmd_ctrl;
  import rtc_cfg_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [55:0] now_bcd;
  logic        running;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_now;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;

  rtc_cmd_ctrl i_rtc_cmd_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick_1hz  (tick_1hz),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .now_bcd   (now_bcd),
    .running   (running)
  );

  // monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it  = sb.pop_front();
      act = it.is_now ? {7'h0, running, now_bcd} : {32'h0, bus_rdata};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] dw(input logic [7:0] y, m, d, w);
    return {w, d, m, y};
  endfunction
  function automatic logic [31:0] tw(input logic [7:0] h, mi, s);
    return {8'h00, s, mi, h};
  endfunction
  function automatic logic [55:0] nv(input logic [7:0] y, m, d, w, h, mi, s);
    return {s, mi, h, w, d, m, y};
  endfunction

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string req);
    bus_addr = a;
    @(posedge clk);
    sb.push_back('{1'b0, {32'h0, e}, req});
    @(negedge clk);
  endtask

  task automatic chk_now(input logic [55:0] e, input logic run, input string req);
    @(posedge clk);
    sb.push_back('{1'b1, {7'h0, run, e}, req});
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [15:0] c);
    wr(A_CTRL, {16'h0, c});
    idle(10);
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    idle(1);
  endtask

  task automatic stage(input logic [31:0] d, input logic [31:0] t);
    wr(A_DATE, d);
    wr(A_TIME, t);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk_rd(A_CTRL, 32'h0, "R1 ctrl after reset");
    chk_now(nv(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0, "R1 time after reset");

    // R5 invalid day while stopped; R8 tick ignored when stopped
    stage(dw(8'h24, 8'h02, 8'h00, 8'h06), tw(8'h23, 8'h59, 8'h59));
    do_cmd(16'd1);
    chk_rd(A_CTRL, 32'h4000, "R5 day 00 rejected");
    tick();
    chk_now(nv(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0, "R5 R8 unchanged and stopped");

    // R12 readback of staged words
    stage(dw(8'h24, 8'h02, 8'h28, 8'h06), tw(8'h23, 8'h59, 8'h59));
    chk_rd(A_DATE, 32'h06280224, "R12 date readback");
    chk_rd(A_TIME, 32'h00595923, "R12 time readback");
    wr(A_CFG, 32'h0);
    wr(A_OFFS, 32'h0000_0E10);

    // R2 exact busy window and R4 commit
    wr(A_CTRL, 32'd1);
    chk_rd(A_CTRL, 32'h8000, "R2 busy first cycle");
    idle(6);
    chk_rd(A_CTRL, 32'h8000, "R2 busy eighth cycle");
    chk_rd(A_CTRL, 32'h0000, "R2 R4 done without error");
    idle(2);
    chk_now(nv(8'h24, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h59), 1'b1, "R4 loaded and running");

    // R9 leap February, R10 weekday 6 -> 0
    tick();
    chk_now(nv(8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, 8'h00), 1'b1, "R9 R10 leap day");

    // R9 non-leap February
    stage(dw(8'h23, 8'h02, 8'h28, 8'h02), tw(8'h23, 8'h59, 8'h59));
    do_cmd(16'd1);
    tick();
    chk_now(nv(8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00), 1'b1, "R9 non-leap Feb 28");

    // R9 thirty-day month
    stage(dw(8'h21, 8'h04, 8'h30, 8'h05), tw(8'h23, 8'h59, 8'h59));
    do_cmd(16'd1);
    tick();
    chk_now(nv(8'h21, 8'h05, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00), 1'b1, "R9 April 30");

    // R8 century wrap
    stage(dw(8'h99, 8'h12, 8'h31, 8'h04), tw(8'h23, 8'h59, 8'h59));
    do_cmd(16'd1);
    tick();
    chk_now(nv(8'h00, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00), 1'b1, "R8 year 99 wraps");

    // R8 minute carry with BCD digit rollover
    stage(dw(8'h21, 8'h05, 8'h01, 8'h06), tw(8'h10, 8'h09, 8'h59));
    do_cmd(16'd1);
    tick();
    chk_now(nv(8'h21, 8'h05, 8'h01, 8'h06, 8'h10, 8'h10, 8'h00), 1'b1, "R8 minute carry");

    // R11 12-hour display
    wr(A_CFG, 32'h1);
    wr(A_OFFS, 32'hFFFF_FFC4);
    stage(dw(8'h21, 8'h05, 8'h01, 8'h06), tw(8'h13, 8'h05, 8'h00));
    do_cmd(16'd1);
    chk_now(nv(8'h21, 8'h05, 8'h01, 8'h06, 8'h81, 8'h05, 8'h00), 1'b1, "R11 13h shows PM 01");
    stage(dw(8'h21, 8'h05, 8'h01, 8'h06), tw(8'h00, 8'h30, 8'h00));
    do_cmd(16'd1);
    chk_now(nv(8'h21, 8'h05, 8'h01, 8'h06, 8'h12, 8'h30, 8'h00), 1'b1, "R11 midnight shows 12");

    // R6 capture
    wr(A_CFG, 32'h55);
    wr(A_OFFS, 32'h99);
    chk_rd(A_CFG, 32'h55, "R12 cfg readback");
    do_cmd(16'd2);
    chk_rd(A_CTRL, 32'h0, "R6 capture ok");
    chk_rd(A_CFG, 32'h1, "R6 captured cfg");
    chk_rd(A_OFFS, 32'hFFFF_FFC4, "R6 captured offset");

    // R5 invalid month, nibble, hour while running
    stage(dw(8'h21, 8'h13, 8'h01, 8'h06), tw(8'h05, 8'h00, 8'h00));
    do_cmd(16'd1);
    chk_rd(A_CTRL, 32'h4000, "R5 month 13 rejected");
    stage(dw(8'h21, 8'h05, 8'h01, 8'h06), tw(8'h05, 8'h5A, 8'h00));
    do_cmd(16'd1);
    chk_rd(A_CTRL, 32'h4000, "R5 bad nibble rejected");
    stage(dw(8'h21, 8'h05, 8'h01, 8'h06), tw(8'h24, 8'h00, 8'h00));
    do_cmd(16'd1);
    chk_rd(A_CTRL, 32'h4000, "R5 hour 24 rejected");
    chk_now(nv(8'h21, 8'h05, 8'h01, 8'h06, 8'h12, 8'h30, 8'h00), 1'b1, "R5 clock kept");

    // R7 clear error
    wr(A_CTRL, 32'd0);
    chk_rd(A_CTRL, 32'h0, "R7 error cleared");

    // R3 writes during busy ignored: bad code, then a valid commit while busy
    stage(dw(8'h22, 8'h07, 8'h04, 8'h01), tw(8'h08, 8'h00, 8'h00));
    wr(A_CTRL, 32'd7);
    wr(A_CTRL, 32'd1);
    idle(6);
    chk_rd(A_CTRL, 32'h8000, "R3 busy not extended yet");
    chk_rd(A_CTRL, 32'h4000, "R3 R6 bad code result kept");
    idle(2);
    chk_now(nv(8'h21, 8'h05, 8'h01, 8'h06, 8'h12, 8'h30, 8'h00), 1'b1, "R3 ignored commit");

    idle(3);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule